// File: doc/BRIEF.md
# Pixel Framebuffer Clear and Sprite Blitter

This block is a small sequencer that owns the write side of a monochrome 64x32 pixel store. The store holds one bit per pixel and is reached through a port that touches exactly one pixel per access. The block has no bulk path into the store, so every operation walks the pixels one at a time. It serves two commands. A clear command blanks the whole screen. A draw command overlays an 8-pixel-wide sprite onto the screen with exclusive-OR and reports whether any lit pixel went dark.

For a draw, the caller supplies a screen origin, a sprite pointer and a row count of 0 to 15. For each row the block reads one byte from a byte-wide sprite memory. It then reads each of the eight target pixels, combines it with one sprite bit and writes the result back. When the command completes the block raises a one-cycle done pulse, and the collision result is valid in that same cycle. Decoding of the instruction that issues the command, the sprite memory itself and display scan-out all sit outside this block.

Top module: `fb_blitter`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`, `done`, `collision`, `fb_we`, `fb_re` and `spr_rd` are all 0.
- R2: A clear writes the value 0 to every one of the 2048 pixels, one pixel per cycle on consecutive cycles. The done pulse appears 2048 cycles after the edge that accepts the command.
- R3: Clear visits addresses in increasing order of the 11-bit value {x, y} (x in bits 10:5, y in bits 4:0), from {0,0} to {63,31}. Y therefore advances fastest.
- R4: A draw handles each pixel in two cycles. The first cycle asserts `fb_re` with the pixel address. The next cycle asserts `fb_we` at the same address, and its data is the read bit XOR the sprite bit. `fb_re` and `fb_we` are never asserted together.
- R5: Sprite row r is fetched from address `spr_base + r` (modulo 4096) with `spr_rd` held high for one cycle. The byte is sampled one cycle later. Bit 7 of the byte lands at column x+0 and bit 0 lands at column x+7.
- R6: The pixel for row r and bit column c is at ((x + c) mod 64, (y + r) mod 32), so a sprite wraps around the screen edges.
- R7: `collision` is cleared when any command is accepted. It becomes 1 during a draw if at least one pixel that read as 1 is written as 0, and it holds until the next command is accepted.
- R8: A draw of N rows produces its done pulse 18*N cycles after the accepting edge. With N = 0 the pulse appears in the very next cycle and no pixel is touched.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance through the done cycle and low in the cycle after it.
- R10: Start requests that arrive while `busy` is high are ignored. If both starts are asserted in the same idle cycle, the clear is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_start | input | 1 | Request a full-screen clear |
| draw_start | input | 1 | Request a sprite draw |
| org_x | input | 6 | Sprite origin column |
| org_y | input | 5 | Sprite origin row |
| row_cnt | input | 4 | Number of sprite rows, 0 to 15 |
| spr_base | input | 12 | Sprite memory address of row 0 |
| spr_rd | output | 1 | Sprite byte read strobe |
| spr_addr | output | 12 | Sprite byte address |
| spr_data | input | 8 | Sprite byte, valid one cycle after `spr_rd` |
| fb_x | output | 6 | Pixel column address |
| fb_y | output | 5 | Pixel row address |
| fb_re | output | 1 | Pixel read strobe; data returns next cycle |
| fb_we | output | 1 | Pixel write strobe |
| fb_wdata | output | 1 | Pixel write value |
| fb_rdata | input | 1 | Pixel read value, valid one cycle after `fb_re` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was turned off by the last draw |

## Verification
The hardest case to reach from the ports is a collision on a pixel that lies across a screen edge. Producing it needs a screen that already holds lit pixels exactly where a wrapped sprite lands. The stimulus reaches it in two ways. First, a directed sprite placed near the bottom-right corner is drawn twice, which must flag a collision and restore the original pixels. Second, random draws with random origins and pointers run on a screen that is preloaded with random content, and the bench tracks a shadow copy of that screen. Start requests issued mid-command are also injected, so that the ignore rule is seen during both a clear and a draw.

// File: rtl/fbb_pkg.sv
// Shared definitions for the framebuffer clear / sprite blitter.
// Assumes: nothing beyond the enum encoding being private to the block.
package fbb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_FETCH,
        ST_LATCH,
        ST_RD,
        ST_WR,
        ST_DONE
    } fbb_state_t;
endpackage

// File: rtl/fbb_scan_ctr.sv
// Linear pixel scanner for the clear command.
// Steps through {x, y} as one counter, so y advances fastest.
// Assumes: restart and adv are never both needed in the same cycle.
module fbb_scan_ctr #(
    parameter int XW = 6,
    parameter int YW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          adv,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          last
);
    localparam int NW = XW + YW;

    logic [NW-1:0] cnt_q;

    // Scan position: zeroed on restart, advanced once per clear cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (adv)     cnt_q <= cnt_q + 1'b1;
    end

    assign x    = cnt_q[NW-1:YW];
    assign y    = cnt_q[YW-1:0];
    assign last = &cnt_q;
endmodule

// File: rtl/fbb_walker.sv
// Row/column position inside a sprite being drawn.
// The column wraps after SW bits and then the row advances.
// Assumes: SW is a power of two no larger than 2**CW.
module fbb_walker #(
    parameter int RW = 4,
    parameter int CW = 3,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          col_last
);
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;

    assign col_last = (col_q == CW'(SW - 1));
    assign row      = row_q;
    assign col      = col_q;

    // Position update: one step per written pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            row_q <= '0;
            col_q <= '0;
        end else if (step) begin
            if (col_last) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbb_row_shift.sv
// Holds the current sprite byte and presents its next bit, MSB first.
// Assumes: load and shift are never both asserted.
module fbb_row_shift #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [SW-1:0] din,
    output logic          msb
);
    logic [SW-1:0] sr_q;

    // Byte register: captures a fetched row, then shifts left per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= din;
        else if (shift) sr_q <= {sr_q[SW-2:0], 1'b0};
    end

    assign msb = sr_q[SW-1];
endmodule

// File: rtl/fb_blitter.sv
// Framebuffer clear and XOR sprite blitter over a one-pixel memory port.
// Clear: one zero write per cycle over all pixels.
// Draw: per row, one fetch cycle, one latch cycle, then read+write per pixel.
// Assumes: sprite and pixel memories return read data one cycle after the strobe.
module fb_blitter #(
    parameter int XW = 6,
    parameter int YW = 5,
    parameter int AW = 12,
    parameter int RW = 4,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_start,
    input  logic          draw_start,
    input  logic [XW-1:0] org_x,
    input  logic [YW-1:0] org_y,
    input  logic [RW-1:0] row_cnt,
    input  logic [AW-1:0] spr_base,
    output logic          spr_rd,
    output logic [AW-1:0] spr_addr,
    input  logic [SW-1:0] spr_data,
    output logic [XW-1:0] fb_x,
    output logic [YW-1:0] fb_y,
    output logic          fb_re,
    output logic          fb_we,
    output logic          fb_wdata,
    input  logic          fb_rdata,
    output logic          busy,
    output logic          done,
    output logic          collision
);
    import fbb_pkg::*;

    localparam int CW = $clog2(SW);

    fbb_state_t    state_q, state_d;
    logic [XW-1:0] ox_q;
    logic [YW-1:0] oy_q;
    logic [AW-1:0] base_q;
    logic [RW-1:0] nrows_q;
    logic          coll_q;

    logic          start_ok;
    logic [XW-1:0] scan_x;
    logic [YW-1:0] scan_y;
    logic          scan_last;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    logic          col_last;
    logic          row_last;
    logic          spr_bit;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;

    assign start_ok = (state_q == ST_IDLE) && (clr_start || draw_start);
    assign row_last = (row == nrows_q - RW'(1));
    assign pix_x    = ox_q + XW'(col);
    assign pix_y    = oy_q + YW'(row);

    fbb_scan_ctr #(.XW(XW), .YW(YW)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_ok),
        .adv     (state_q == ST_CLEAR),
        .x       (scan_x),
        .y       (scan_y),
        .last    (scan_last)
    );

    fbb_walker #(.RW(RW), .CW(CW), .SW(SW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start_ok),
        .step     (state_q == ST_WR),
        .row      (row),
        .col      (col),
        .col_last (col_last)
    );

    fbb_row_shift #(.SW(SW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_LATCH),
        .shift (state_q == ST_WR),
        .din   (spr_data),
        .msb   (spr_bit)
    );

    // Command sequencing; clear wins when both starts arrive together.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (clr_start)       state_d = ST_CLEAR;
                else if (draw_start) state_d = (row_cnt == '0) ? ST_DONE : ST_FETCH;
            end
            ST_CLEAR: if (scan_last) state_d = ST_DONE;
            ST_FETCH: state_d = ST_LATCH;
            ST_LATCH: state_d = ST_RD;
            ST_RD:    state_d = ST_WR;
            ST_WR: begin
                if (col_last) state_d = row_last ? ST_DONE : ST_FETCH;
                else          state_d = ST_RD;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command operands, captured when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ox_q    <= '0;
            oy_q    <= '0;
            base_q  <= '0;
            nrows_q <= '0;
        end else if (start_ok) begin
            ox_q    <= org_x;
            oy_q    <= org_y;
            base_q  <= spr_base;
            nrows_q <= row_cnt;
        end
    end

    // Collision flag: cleared on acceptance, set when a lit pixel goes dark.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          coll_q <= 1'b0;
        else if (start_ok)                                   coll_q <= 1'b0;
        else if (state_q == ST_WR && fb_rdata && spr_bit)    coll_q <= 1'b1;
    end

    // Memory-port and status outputs decoded from the state.
    always_comb begin
        spr_rd   = (state_q == ST_FETCH);
        spr_addr = base_q + AW'(row);
        fb_re    = (state_q == ST_RD);
        fb_we    = (state_q == ST_CLEAR) || (state_q == ST_WR);
        fb_wdata = (state_q == ST_WR) && (fb_rdata ^ spr_bit);
        fb_x     = (state_q == ST_CLEAR) ? scan_x : pix_x;
        fb_y     = (state_q == ST_CLEAR) ? scan_y : pix_y;
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
    end

    assign collision = coll_q;
endmodule

// File: rtl/fbb_checker.sv
// Port-level protocol checks for fb_blitter, attached through bind.
// Assumes: synchronous active-low reset on rst_n.
module fbb_checker #(
    parameter int XW = 6,
    parameter int YW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          busy,
    input logic          fb_re,
    input logic          fb_we,
    input logic [XW-1:0] fb_x,
    input logic [YW-1:0] fb_y,
    input logic          spr_rd
);
    localparam int NW = XW + YW;

    logic [NW-1:0] cur_addr;
    assign cur_addr = {fb_x, fb_y};

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_re && fb_we)); // R4

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        fb_re |=> (fb_we && $stable(fb_x) && $stable(fb_y))); // R4

    AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> (cur_addr == NW'($past(cur_addr) + 1'b1))); // R3

    AST_SPR_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        spr_rd |=> !spr_rd); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fb_we && !fb_re && !spr_rd)); // R10
endmodule

bind fb_blitter fbb_checker #(.XW(XW), .YW(YW)) u_fbb_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .busy   (busy),
    .fb_re  (fb_re),
    .fb_we  (fb_we),
    .fb_x   (fb_x),
    .fb_y   (fb_y),
    .spr_rd (spr_rd)
);

// File: tb/tb_fb_blitter.sv
`timescale 1ns/1ps
module tb_fb_blitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_start = 1'b0;
    logic        draw_start = 1'b0;
    logic [5:0]  org_x = '0;
    logic [4:0]  org_y = '0;
    logic [3:0]  row_cnt = '0;
    logic [11:0] spr_base = '0;
    logic        spr_rd;
    logic [11:0] spr_addr;
    logic [7:0]  spr_data;
    logic [5:0]  fb_x;
    logic [4:0]  fb_y;
    logic        fb_re, fb_we, fb_wdata;
    logic        fb_rdata;
    logic        busy, done, collision;

    logic [7:0]  smem [4096];
    logic        fbm  [2048];
    logic        exp_fb [2048];
    logic        ld_en = 1'b0;
    logic [10:0] ld_a = '0;
    logic        ld_d = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    fb_blitter dut (
        .clk(clk), .rst_n(rst_n), .clr_start(clr_start), .draw_start(draw_start),
        .org_x(org_x), .org_y(org_y), .row_cnt(row_cnt), .spr_base(spr_base),
        .spr_rd(spr_rd), .spr_addr(spr_addr), .spr_data(spr_data),
        .fb_x(fb_x), .fb_y(fb_y), .fb_re(fb_re), .fb_we(fb_we),
        .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
        .busy(busy), .done(done), .collision(collision)
    );

    // Memory models: one-cycle read latency on both ports.
    always @(posedge clk) begin
        if (spr_rd) spr_data <= smem[spr_addr];
        if (fb_re)  fb_rdata <= fbm[{fb_x, fb_y}];
        if (fb_we)      fbm[{fb_x, fb_y}] <= fb_wdata;
        else if (ld_en) fbm[ld_a] <= ld_d;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cmp_fb(input string req, input string what);
        int mis = 0;
        for (int i = 0; i < 2048; i++)
            if (fbm[i] !== exp_fb[i]) mis++;
        check(mis == 0, req, {what, " pixel mismatches"}, mis, 0);
    endtask

    // Expected result of a draw on the shadow screen; returns the collision.
    function automatic bit model_draw(input logic [5:0] ox, input logic [4:0] oy,
                                      input int rows, input logic [11:0] base);
        bit coll = 1'b0;
        for (int r = 0; r < rows; r++) begin
            logic [7:0] b = smem[12'(base + 12'(r))];
            for (int c = 0; c < 8; c++) begin
                logic [5:0] px = 6'(ox + 6'(c));
                logic [4:0] py = 5'(oy + 5'(r));
                logic       sb = b[7 - c];
                if (sb && exp_fb[{px, py}]) coll = 1'b1;
                exp_fb[{px, py}] = exp_fb[{px, py}] ^ sb;
            end
        end
        return coll;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 2048; i++) exp_fb[i] = 1'b0;
    endfunction

    // Issue one command; poke_kind 1 = draw_start, 2 = clr_start at cycle poke_at.
    task automatic run_cmd(input bit is_clr, input bit also_draw,
                           input logic [5:0] ox, input logic [4:0] oy,
                           input logic [3:0] rows, input logic [11:0] base,
                           input int poke_kind, input int poke_at,
                           output int cycles);
        int n = 0;
        @(negedge clk);
        org_x = ox; org_y = oy; row_cnt = rows; spr_base = base;
        clr_start = is_clr;
        draw_start = also_draw;
        @(posedge clk);
        forever begin
            @(negedge clk);
            clr_start = 1'b0;
            draw_start = 1'b0;
            if (done) break;
            n++;
            if (n == poke_at && poke_kind == 1) draw_start = 1'b1;
            if (n == poke_at && poke_kind == 2) clr_start = 1'b1;
            if (n > 6000) begin
                check(1'b0, "R9", "done never seen", n, 0);
                break;
            end
        end
        cycles = n;
        @(negedge clk);
        check(!done && !busy, "R9", "done pulse length / busy after", {done, busy}, 0);
    endtask

    initial begin
        int          cyc;
        bit          ec;
        logic [5:0]  rx;
        logic [4:0]  ry;
        logic [3:0]  rr;
        logic [11:0] rb;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 4096; i++) smem[i] = 8'($urandom);
        smem[100] = 8'h80;
        for (int i = 200; i < 204; i++) smem[i] = 8'hFF;
        smem[4094] = 8'hA5; smem[4095] = 8'h3C; smem[0] = 8'h81; smem[1] = 8'h7E;

        // R1: reset state
        repeat (3) @(negedge clk);
        check({busy, done, collision, fb_we, fb_re, spr_rd} == 6'b0, "R1",
              "outputs in reset", {busy, done, collision, fb_we, fb_re, spr_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, collision, fb_we, fb_re, spr_rd} == 6'b0, "R1",
              "outputs after reset", {busy, done, collision, fb_we, fb_re, spr_rd}, 0);

        // Random preload of the screen through the bench port.
        for (int i = 0; i < 2048; i++) begin
            exp_fb[i] = 1'($urandom);
            ld_en = 1'b1; ld_a = 11'(i); ld_d = exp_fb[i];
            @(negedge clk);
        end
        ld_en = 1'b0;

        // R2 R3: clear of a random screen
        run_cmd(1'b1, 1'b0, 6'd0, 5'd0, 4'd0, 12'd0, 0, 0, cyc);
        model_clear();
        check(cyc == 2048, "R2", "clear cycles", cyc, 2048);
        cmp_fb("R2", "clear");
        check(collision == 1'b0, "R7", "collision after clear", collision, 0);

        // R5: MSB lands on the leftmost column
        run_cmd(1'b0, 1'b1, 6'd5, 5'd3, 4'd1, 12'd100, 0, 0, cyc);
        ec = model_draw(6'd5, 5'd3, 1, 12'd100);
        check(cyc == 18, "R8", "one-row draw cycles", cyc, 18);
        check(fbm[{6'd5, 5'd3}] == 1'b1 && fbm[{6'd12, 5'd3}] == 1'b0, "R5",
              "bit7 at x+0", {fbm[{6'd5, 5'd3}], fbm[{6'd12, 5'd3}]}, 2);
        cmp_fb("R5", "msb draw");

        // R6: wrap at bottom-right corner
        run_cmd(1'b0, 1'b1, 6'd60, 5'd30, 4'd4, 12'd200, 0, 0, cyc);
        ec = model_draw(6'd60, 5'd30, 4, 12'd200);
        cmp_fb("R6", "wrapped draw");
        check(collision == ec, "R7", "no collision on blank area", collision, ec);

        // R7: same sprite again erases it and collides
        run_cmd(1'b0, 1'b1, 6'd60, 5'd30, 4'd4, 12'd200, 0, 0, cyc);
        ec = model_draw(6'd60, 5'd30, 4, 12'd200);
        check(collision == 1'b1 && ec, "R7", "redraw collision", collision, 1);
        cmp_fb("R6", "redraw restores");
        check(cyc == 72, "R8", "four-row draw cycles", cyc, 72);

        // R8: zero rows; R7 flag cleared on acceptance
        run_cmd(1'b0, 1'b1, 6'd1, 5'd1, 4'd0, 12'd0, 0, 0, cyc);
        check(cyc == 0, "R8", "zero-row draw cycles", cyc, 0);
        check(collision == 1'b0, "R7", "flag cleared at start", collision, 0);
        cmp_fb("R8", "zero-row untouched");

        // R5: sprite pointer wraps modulo 4096
        run_cmd(1'b0, 1'b1, 6'd20, 5'd10, 4'd4, 12'd4094, 0, 0, cyc);
        ec = model_draw(6'd20, 5'd10, 4, 12'd4094);
        cmp_fb("R5", "pointer wrap");
        check(collision == ec, "R7", "pointer wrap collision", collision, ec);

        // Random draws on a shared screen
        for (int k = 0; k < 30; k++) begin
            rx = 6'($urandom); ry = 5'($urandom);
            rr = 4'($urandom); rb = 12'($urandom);
            run_cmd(1'b0, 1'b1, rx, ry, rr, rb, 0, 0, cyc);
            ec = model_draw(rx, ry, int'(rr), rb);
            check(cyc == 18 * int'(rr), "R8", "random draw cycles", cyc, 18 * int'(rr));
            check(collision == ec, "R7", "random collision", collision, ec);
            cmp_fb("R6", "random draw");
        end

        // R10: clear request during a draw is ignored
        run_cmd(1'b0, 1'b1, 6'd40, 5'd7, 4'd3, 12'd300, 2, 5, cyc);
        ec = model_draw(6'd40, 5'd7, 3, 12'd300);
        check(cyc == 54, "R10", "draw length with clear poke", cyc, 54);
        cmp_fb("R10", "draw with clear poke");

        // R10: draw request during a clear is ignored
        run_cmd(1'b1, 1'b0, 6'd3, 5'd3, 4'd5, 12'd200, 1, 100, cyc);
        model_clear();
        check(cyc == 2048, "R10", "clear length with draw poke", cyc, 2048);
        cmp_fb("R10", "clear with draw poke");

        // R10: simultaneous starts pick the clear
        ec = model_draw(6'd9, 5'd9, 4, 12'd200);
        run_cmd(1'b0, 1'b1, 6'd9, 5'd9, 4'd4, 12'd200, 0, 0, cyc);
        run_cmd(1'b1, 1'b1, 6'd9, 5'd9, 4'd4, 12'd200, 0, 0, cyc);
        model_clear();
        check(cyc == 2048, "R10", "both starts cycles", cyc, 2048);
        cmp_fb("R10", "both starts clears");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #1_900_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule